// File: doc/BRIEF.md
# Protected Latched Output Controller

This block is the digital core of an eight-channel output driver that has fault protection. A parallel data word is captured into per-channel latches under a strobe, and a clear control empties them. Each channel's latch then produces an output-drive enable. An active-high disable/reset control gates every output. Each channel has its own overcurrent sense bit. The bit passes through a debounce counter, so brief current spikes are ignored. A sustained overcurrent latches a fault that switches off only the affected channel.

A live overtemperature bit switches off all channels without being remembered. An undervoltage bit acts exactly like the disable/reset control. An active-low flag reports any latched overcurrent or a present overtemperature. The whole design runs on one system clock with a synchronous active-low reset. The debounce length is derived from a time window and the clock period.

Top module: `prot_latch_ctrl`

## Requirements
- R1: After a clock edge with `rst_n` low, every `drive` bit is 0 and `flag_n` is 1, and the latches, fault state and debounce counters are emptied.
- R2: At a clock edge with `load` high and `wipe` low, each latch takes its `din` bit. With `load` low, the latches keep their value.
- R3: At a clock edge with `wipe` high, all latches become 0 whatever `load` and `din` are.
- R4: While `dis_rst` is 1, every `drive` bit is 0 in the same cycle. The latch contents are kept, so `drive` shows the latched word again once `dis_rst` returns to 0 (with no fault and no overtemperature).
- R5: An overcurrent sense bit that is high for fewer than FILT_CYCLES consecutive clock edges sets no fault. A low edge restarts the count from zero.
- R6: When `oc_sense[i]` is high for FILT_CYCLES consecutive edges, channel i's fault is set at the last of those edges. From then on `drive[i]` is 0, and the other channels are unaffected. FILT_CYCLES equals FILTER_NS divided by CLK_PERIOD_NS, which is 200 by default.
- R7: A latched fault persists after its sense bit drops. It is cleared only at an edge where `dis_rst` or `uv` is high, or by reset. If the clear arrives at the edge where the debounce count would expire, the clear wins.
- R8: While `ot` is 1, every `drive` bit is 0 and `flag_n` is 0. When `ot` falls, the outputs recover with no reset pulse.
- R9: While `uv` is 1, every `drive` bit is 0. An edge with `uv` high clears all latched faults and debounce counts.
- R10: `flag_n` is 0 exactly when any channel fault is latched or `ot` is 1. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 8 | Parallel data, one bit per channel |
| load | input | 1 | Latches follow `din` at edges while high |
| wipe | input | 1 | Empties all latches; has priority over `load` |
| dis_rst | input | 1 | High: all outputs off and faults cleared |
| oc_sense | input | 8 | Per-channel overcurrent sense |
| ot | input | 1 | Overtemperature sense, not latched |
| uv | input | 1 | Undervoltage sense, acts as `dis_rst` |
| drive | output | 8 | Per-channel output-drive enable |
| flag_n | output | 1 | Active-low fault flag |

## Verification
Two events can fall on the same edge: the debounce counter expiring, and a fault clear from `dis_rst`. To provoke this, a channel's sense bit is held high for FILT_CYCLES-1 edges. `dis_rst` then rises just before the edge at which the fault would be set, with the sense bit still high. The result is judged after the disable is released. The flag must be high and all latched channels must drive again, because the clear has priority. A second coincidence is also checked: `wipe` and `load` are raised together, and the latches must end up empty.

// File: rtl/plc_pkg.sv
// Package: shared helpers for the protected latched output controller.
// Assumes time values are integers in nanoseconds.
package plc_pkg;

    // Number of whole clock cycles that cover a time window (at least 1).
    function automatic int window_cycles(input int window_ns, input int period_ns);
        int n;
        n = window_ns / period_ns;
        return (n < 1) ? 1 : n;
    endfunction

endpackage

// File: rtl/plc_data_latch.sv
// Module: bank of data latches, modelled as clocked registers.
// A wipe empties the bank and takes priority over load; load captures din.
// Assumes synchronous active-low reset.
module plc_data_latch #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              wipe,
    input  logic [NUM_CH-1:0] din,
    output logic [NUM_CH-1:0] lat_q
);

    // Capture, wipe or hold the latch bank.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe)
            lat_q <= '0;
        else if (load)
            lat_q <= din;
    end

    // R3
    property wipe_empties_p;
        @(posedge clk) disable iff (!rst_n) wipe |=> (lat_q == '0);
    endproperty
    wipe_empties_chk: assert property (wipe_empties_p);

    // R2
    property hold_when_idle_p;
        @(posedge clk) disable iff (!rst_n) (!load && !wipe) |=> $stable(lat_q);
    endproperty
    hold_when_idle_chk: assert property (hold_when_idle_p);

endmodule

// File: rtl/plc_oc_filter.sv
// Module: one channel's overcurrent debounce counter and fault latch.
// The fault is set after FILT_CYCLES consecutive high samples. A low sample
// restarts the count. clr (disable or undervoltage) empties count and fault.
// Assumes FILT_CYCLES >= 1 and a synchronous active-low reset.
module plc_oc_filter #(
    parameter int FILT_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sense,
    output logic fault
);

    localparam int CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Count consecutive high samples and latch the fault on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt   <= '0;
            fault <= 1'b0;
        end else if (!sense) begin
            cnt <= '0;
        end else if (!fault) begin
            if (cnt == LAST)
                fault <= 1'b1;
            else
                cnt <= cnt + 1'b1;
        end
    end

    // R5
    property no_set_after_low_p;
        @(posedge clk) disable iff (!rst_n) !sense |=> !$rose(fault);
    endproperty
    no_set_after_low_chk: assert property (no_set_after_low_p);

    // R7
    property fault_clears_on_clr_p;
        @(posedge clk) disable iff (!rst_n) $fell(fault) |-> $past(clr);
    endproperty
    fault_clears_on_clr_chk: assert property (fault_clears_on_clr_p);

    // R7
    property clr_wins_p;
        @(posedge clk) disable iff (!rst_n) clr |=> !fault;
    endproperty
    clr_wins_chk: assert property (clr_wins_p);

endmodule

// File: rtl/plc_out_gate.sv
// Module: combines the latch data, channel faults and global shut-offs into
// the drive enables and the active-low flag. Purely combinational.
module plc_out_gate #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] lat_q,
    input  logic [NUM_CH-1:0] fault_vec,
    input  logic              dis_rst,
    input  logic              uv,
    input  logic              ot,
    output logic [NUM_CH-1:0] drive,
    output logic              flag_n
);

    logic all_off;

    // Gate each latch by its own fault and by the global shut-off sources.
    always_comb begin
        all_off = dis_rst | uv | ot;
        drive   = lat_q & ~fault_vec & {NUM_CH{~all_off}};
        flag_n  = ~((|fault_vec) | ot);
    end

    // R4
    property dis_forces_off_p;
        @(posedge clk) disable iff (!rst_n) dis_rst |-> (drive == '0);
    endproperty
    dis_forces_off_chk: assert property (dis_forces_off_p);

    // R8
    property ot_forces_off_p;
        @(posedge clk) disable iff (!rst_n) ot |-> (drive == '0 && !flag_n);
    endproperty
    ot_forces_off_chk: assert property (ot_forces_off_p);

    // R10
    property fault_lowers_flag_p;
        @(posedge clk) disable iff (!rst_n) (fault_vec != '0) |-> !flag_n;
    endproperty
    fault_lowers_flag_chk: assert property (fault_lowers_flag_p);

    // R9
    property uv_forces_off_p;
        @(posedge clk) disable iff (!rst_n) uv |-> (drive == '0);
    endproperty
    uv_forces_off_chk: assert property (uv_forces_off_p);

endmodule

// File: rtl/prot_latch_ctrl.sv
// Module: top of the protected latched output controller. It holds the data
// latch bank, one overcurrent filter per channel and the output gating.
// Assumes one clock domain and sense inputs already synchronised.
module prot_latch_ctrl #(
    parameter int NUM_CH        = 8,
    parameter int FILTER_NS     = 2000,
    parameter int CLK_PERIOD_NS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] din,
    input  logic              load,
    input  logic              wipe,
    input  logic              dis_rst,
    input  logic [NUM_CH-1:0] oc_sense,
    input  logic              ot,
    input  logic              uv,
    output logic [NUM_CH-1:0] drive,
    output logic              flag_n
);

    localparam int FILT_CYCLES = plc_pkg::window_cycles(FILTER_NS, CLK_PERIOD_NS);

    logic [NUM_CH-1:0] lat_q;
    logic [NUM_CH-1:0] fault_vec;
    logic              fault_clr;

    // Undervoltage behaves exactly like the disable/reset control.
    assign fault_clr = dis_rst | uv;

    plc_data_latch #(.NUM_CH(NUM_CH)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .wipe  (wipe),
        .din   (din),
        .lat_q (lat_q)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_filt
        plc_oc_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (fault_clr),
            .sense (oc_sense[ch]),
            .fault (fault_vec[ch])
        );
    end

    plc_out_gate #(.NUM_CH(NUM_CH)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .lat_q     (lat_q),
        .fault_vec (fault_vec),
        .dis_rst   (dis_rst),
        .uv        (uv),
        .ot        (ot),
        .drive     (drive),
        .flag_n    (flag_n)
    );

    // R6
    property fault_only_with_sense_p;
        @(posedge clk) disable iff (!rst_n)
            (fault_vec & ~$past(fault_vec) & ~$past(oc_sense)) == '0;
    endproperty
    fault_only_with_sense_chk: assert property (fault_only_with_sense_p);

endmodule

// File: tb/prot_latch_ctrl_test.sv
module prot_latch_ctrl_test;

    localparam int FILT = 200;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] din;
    logic       load, wipe, dis_rst, ot, uv;
    logic [7:0] oc_sense;
    logic [7:0] drive;
    logic       flag_n;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    prot_latch_ctrl #(.NUM_CH(8), .FILTER_NS(2000), .CLK_PERIOD_NS(10)) uut (
        .clk(clk), .rst_n(rst_n), .din(din), .load(load), .wipe(wipe),
        .dis_rst(dis_rst), .oc_sense(oc_sense), .ot(ot), .uv(uv),
        .drive(drive), .flag_n(flag_n)
    );

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] dact, input logic [7:0] dexp,
                       input logic fact, input logic fexp);
        tests++;
        if (dact !== dexp || fact !== fexp) begin
            fails++;
            $display("FAIL %s: drive=%h flag_n=%b expected drive=%h flag_n=%b",
                     req, dact, fact, dexp, fexp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(2);
        chk("R1 reset", drive, 8'h00, flag_n, 1'b1);
        rst_n = 1'b1; step(1);
    endtask

    task automatic t_load();
        din = 8'hA5; load = 1'b1; step(1);
        chk("R2 load", drive, 8'hA5, flag_n, 1'b1);
        din = 8'hFF; load = 1'b0; step(2);
        chk("R2 hold", drive, 8'hA5, flag_n, 1'b1);
        din = 8'h3C; load = 1'b1; step(1); load = 1'b0;
        chk("R2 reload", drive, 8'h3C, flag_n, 1'b1);
    endtask

    task automatic t_wipe();
        din = 8'hFF; load = 1'b1; wipe = 1'b1; step(1);
        chk("R3 wipe over load", drive, 8'h00, flag_n, 1'b1);
        wipe = 1'b0; din = 8'h81; step(1); load = 1'b0;
        chk("R3 load after wipe", drive, 8'h81, flag_n, 1'b1);
    endtask

    task automatic t_dis();
        dis_rst = 1'b1; #1;
        chk("R4 disable same cycle", drive, 8'h00, flag_n, 1'b1);
        step(2);
        chk("R4 disable held", drive, 8'h00, flag_n, 1'b1);
        dis_rst = 1'b0; #1;
        chk("R4 latch kept", drive, 8'h81, flag_n, 1'b1);
        din = 8'hFF; load = 1'b1; step(1); load = 1'b0;
    endtask

    task automatic t_short();
        oc_sense[2] = 1'b1; step(FILT - 1); oc_sense[2] = 1'b0; step(1);
        chk("R5 short pulse", drive, 8'hFF, flag_n, 1'b1);
        oc_sense[2] = 1'b1; step(FILT - 1); oc_sense[2] = 1'b0; step(1);
        oc_sense[2] = 1'b1; step(FILT - 1); oc_sense[2] = 1'b0; step(1);
        chk("R5 gap restarts count", drive, 8'hFF, flag_n, 1'b1);
    endtask

    task automatic t_long();
        oc_sense[2] = 1'b1; step(FILT - 1);
        chk("R6 one edge before expiry", drive, 8'hFF, flag_n, 1'b1);
        step(1);
        chk("R6 fault set", drive, 8'hFB, flag_n, 1'b0);
        oc_sense[2] = 1'b0; step(3);
        chk("R7 fault persists", drive, 8'hFB, flag_n, 1'b0);
        dis_rst = 1'b1; step(1); dis_rst = 1'b0; #1;
        chk("R7 disable clears fault", drive, 8'hFF, flag_n, 1'b1);
    endtask

    task automatic t_ot();
        ot = 1'b1; #1;
        chk("R8 ot off", drive, 8'h00, flag_n, 1'b0);
        step(3);
        ot = 1'b0; #1;
        chk("R8 ot not latched", drive, 8'hFF, flag_n, 1'b1);
    endtask

    task automatic t_uv();
        oc_sense[0] = 1'b1; step(FILT); oc_sense[0] = 1'b0;
        chk("R6 fault ch0", drive, 8'hFE, flag_n, 1'b0);
        uv = 1'b1; #1;
        chk("R9 uv off", drive, 8'h00, flag_n, 1'b0);
        step(1); uv = 1'b0; #1;
        chk("R9 uv clears fault", drive, 8'hFF, flag_n, 1'b1);
    endtask

    task automatic t_race();
        oc_sense[5] = 1'b1; step(FILT - 1);
        dis_rst = 1'b1; step(1);
        dis_rst = 1'b0; oc_sense[5] = 1'b0; #1;
        chk("R7 clear wins at expiry", drive, 8'hFF, flag_n, 1'b1);
    endtask

    task automatic t_flag();
        oc_sense = 8'h42; step(FILT); oc_sense = 8'h00;
        chk("R10 two faults", drive, 8'hBD, flag_n, 1'b0);
        dis_rst = 1'b1; step(1); dis_rst = 1'b0; #1;
        chk("R10 flag released", drive, 8'hFF, flag_n, 1'b1);
        rst_n = 1'b0; step(1);
        chk("R1 reset empties latch", drive, 8'h00, flag_n, 1'b1);
        rst_n = 1'b1;
    endtask

    initial begin
        din = '0; load = 0; wipe = 0; dis_rst = 0; ot = 0; uv = 0; oc_sense = '0;
        rst_n = 1'b0;
        step(1);
        t_reset();
        t_load();
        t_wipe();
        t_dis();
        t_short();
        t_long();
        t_ot();
        t_uv();
        t_race();
        t_flag();
        step(2);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule